// File: doc/BRIEF.md
# Clock Lock-Wait Output Gate

This block sits between a spread-spectrum clock synthesiser and the logic that uses its output. It holds the delivered clock low and keeps a ready flag deasserted whenever the synthesiser cannot be trusted. That is the case while the active-low power-down input is asserted, and for a fixed settling interval after power-down is released. The same interval applies after any change to the frequency-range select or to the modulation enable. Once the interval has run out, the generated clock passes through a glitch-free latch-based gate and the ready flag goes high.

The settling interval is counted on a free-running timing clock. A prescaler divides that clock down to milliseconds using a parameter for the number of timing-clock cycles per millisecond. The interval is longer when the highest frequency range is selected. All control inputs are asynchronous to the timing clock, so each passes through two flip-flop stages. A registered copy of the configuration is compared with the synchronised value on every cycle, and any difference restarts the wait from zero.

Top module: `clk_lockwait_gate`

## Requirements
- R1: During and directly after reset, `clk_ready` is 0 and `clk_out` is 0. The synchronised power-down input resets to the inactive (running) level, so when `pd_n` is high a settling wait begins at the first timing-clock edge after reset is released.
- R2: When `pd_n` goes low, `clk_ready` is 0 from the third rising timing-clock edge onward. `clk_out` stays low from the fourth edge onward, for as long as `pd_n` stays low.
- R3: When `pd_n` rises (or a change in R4 occurs), `clk_ready` stays 0 through timing-clock edge W*TICKS_PER_MS+2 after the input change and becomes 1 at edge W*TICKS_PER_MS+3. After reset with `pd_n` high, it becomes 1 at edge W*TICKS_PER_MS+1.
- R4: A change of `range_sel` or `mod_en` while ready drops `clk_ready` at the third rising edge after the change, and starts a full wait.
- R5: A change during an ongoing wait restarts the count from zero, so the wait is measured from the last change.
- R6: W is WAIT_MS_HI (default 8) milliseconds when `range_sel` is 2'b01, the highest range, and WAIT_MS_LO (default 5) for the codes 2'b00, 2'b10 and 2'b11.
- R7: While `clk_ready` is 1, `clk_out` follows `gen_clk`. Its first high phase starts at the `gen_clk` rising edge after the one on which `clk_ready` rose. Enable changes take effect only while `gen_clk` is low, so no shortened pulse appears.
- R8: Driving `range_sel` and `mod_en` again with the values they already hold has no effect: `clk_ready` stays 1 and `clk_out` keeps toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tmr_clk | input | 1 | Free-running timing clock for synchronisers and the wait counter |
| gen_clk | input | 1 | Generated (modulated) clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset, timing-clock domain |
| pd_n | input | 1 | Active-low power-down request, asynchronous |
| range_sel | input | 2 | Frequency-range select, asynchronous; 2'b01 is the highest range |
| mod_en | input | 1 | Modulation enable, asynchronous |
| clk_out | output | 1 | Gated output clock, low while not ready |
| clk_ready | output | 1 | High when the output clock is settled and passing |

## Verification
The bench targets the exact edge on which ready rises for both wait lengths. A design that counted one millisecond too few or too many, or that picked the long wait for the wrong range code, shifts that edge and fails the check made one cycle before or after. A change that arrives half-way through a wait is applied to catch a design that keeps counting instead of restarting, since such a design would assert ready early. Rewriting an unchanged configuration, and holding power-down low while watching the clock's high phases, catch a comparator that triggers on writes rather than on differences, and a gate that lets pulses leak through during power-down.

// File: rtl/clk_lockwait_pkg.sv
package clk_lockwait_pkg;

  typedef enum logic [1:0] {
    LK_OFF  = 2'd0,
    LK_WAIT = 2'd1,
    LK_RUN  = 2'd2
  } lk_state_e;

  typedef struct packed {
    logic [1:0] rng;
    logic       mod_en;
  } lk_cfg_t;

  localparam logic [1:0] RANGE_HIGHEST = 2'b01;

endpackage

// File: rtl/lk_sync2.sv
module lk_sync2 #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/lk_wait_timer.sv
module lk_wait_timer
  import clk_lockwait_pkg::*;
#(
  parameter int TICKS_PER_MS = 100000,
  parameter int WAIT_MS_LO   = 5,
  parameter int WAIT_MS_HI   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_i,
  input  logic restart_i,
  input  logic hi_range_i,
  output logic run_o
);

  localparam int SUB_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam int MS_W  = $clog2(WAIT_MS_HI + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_MS - 1);

  lk_state_e        st_q, st_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic [MS_W-1:0]  tgt_ms;
  logic             upd_en;

  assign tgt_ms = hi_range_i ? MS_W'(WAIT_MS_HI) : MS_W'(WAIT_MS_LO);

  always_comb begin
    st_d  = st_q;
    sub_d = sub_q;
    ms_d  = ms_q;
    if (!pd_i) begin
      st_d  = LK_OFF;
      sub_d = '0;
      ms_d  = '0;
    end else if (restart_i || st_q == LK_OFF) begin
      st_d  = LK_WAIT;
      sub_d = '0;
      ms_d  = '0;
    end else if (st_q == LK_WAIT) begin
      if (sub_q == SUB_LAST) begin
        sub_d = '0;
        if (ms_q == tgt_ms - MS_W'(1)) begin
          st_d = LK_RUN;
          ms_d = '0;
        end else begin
          ms_d = ms_q + MS_W'(1);
        end
      end else begin
        sub_d = sub_q + SUB_W'(1);
      end
    end
  end

  assign upd_en = (st_d != st_q) || (st_q == LK_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LK_OFF;
      sub_q <= '0;
      ms_q  <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      sub_q <= sub_d;
      ms_q  <= ms_d;
    end
  end

  assign run_o = (st_q == LK_RUN);

  p_sub_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= SUB_LAST);

  p_ms_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q < MS_W'(WAIT_MS_HI));

  p_run_from_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> ($past(st_q) == LK_WAIT && $past(sub_q) == SUB_LAST));

endmodule

// File: rtl/lk_clk_gate.sv
module lk_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);

  logic en_lat;

  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign clk_o = clk_i & en_lat;

endmodule

// File: rtl/clk_lockwait_gate.sv
module clk_lockwait_gate
  import clk_lockwait_pkg::*;
#(
  parameter int TICKS_PER_MS = 100000,
  parameter int WAIT_MS_LO   = 5,
  parameter int WAIT_MS_HI   = 8,
  parameter bit GEN_SYNC     = 1'b0
) (
  input  logic       tmr_clk,
  input  logic       gen_clk,
  input  logic       rst_n,
  input  logic       pd_n,
  input  logic [1:0] range_sel,
  input  logic       mod_en,
  output logic       clk_out,
  output logic       clk_ready
);

  localparam int CFG_W = $bits(lk_cfg_t);

  logic             pd_s;
  logic [CFG_W-1:0] cfg_raw;
  lk_cfg_t          cfg_s, cfg_q;
  logic             cfg_chg;
  logic             run;
  logic             gate_en;

  lk_sync2 #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk(tmr_clk), .rst_n(rst_n), .d(pd_n), .q(pd_s)
  );

  lk_sync2 #(.W(CFG_W), .RST_VAL('0)) u_cfg_sync (
    .clk(tmr_clk), .rst_n(rst_n), .d({range_sel, mod_en}), .q(cfg_raw)
  );

  assign cfg_s = lk_cfg_t'(cfg_raw);

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_s;
  end

  assign cfg_chg = (cfg_s != cfg_q);

  lk_wait_timer #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .WAIT_MS_LO  (WAIT_MS_LO),
    .WAIT_MS_HI  (WAIT_MS_HI)
  ) u_timer (
    .clk       (tmr_clk),
    .rst_n     (rst_n),
    .pd_i      (pd_s),
    .restart_i (cfg_chg),
    .hi_range_i(cfg_q.rng == RANGE_HIGHEST),
    .run_o     (run)
  );

  generate
    if (GEN_SYNC) begin : g_en_sync
      lk_sync2 #(.W(1), .RST_VAL(1'b0)) u_en_sync (
        .clk(gen_clk), .rst_n(rst_n), .d(run), .q(gate_en)
      );
    end else begin : g_en_direct
      assign gate_en = run;
    end
  endgenerate

  lk_clk_gate u_gate (
    .clk_i(gen_clk), .en_i(gate_en), .clk_o(clk_out)
  );

  assign clk_ready = run;

  p_pd_drops_ready_r2: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    !pd_s |=> !clk_ready);

  p_cfg_drops_ready_r4: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (pd_s && cfg_chg) |=> !clk_ready);

endmodule

// File: tb/clk_lockwait_gate_tb.sv
module clk_lockwait_gate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TPM        = 4;
  localparam int MS_LO      = 5;
  localparam int MS_HI      = 8;

  logic       clk;
  logic       rst_n;
  logic       pd_n;
  logic [1:0] range_sel;
  logic       mod_en;
  logic       clk_out;
  logic       clk_ready;

  int n_checks = 0;
  int n_fail   = 0;

  clk_lockwait_gate #(
    .TICKS_PER_MS(TPM), .WAIT_MS_LO(MS_LO), .WAIT_MS_HI(MS_HI), .GEN_SYNC(1'b0)
  ) u_dut (
    .tmr_clk(clk), .gen_clk(clk), .rst_n(rst_n), .pd_n(pd_n),
    .range_sel(range_sel), .mod_en(mod_en),
    .clk_out(clk_out), .clk_ready(clk_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // entries: {range_sel, mod_en}; each differs from the one before
  localparam logic [2:0] VEC [0:5] = '{3'b001, 3'b011, 3'b100, 3'b111, 3'b010, 3'b000};

  function automatic int wait_cycles(input logic [1:0] r);
    return ((r == 2'b01) ? MS_HI : MS_LO) * TPM;
  endfunction

  // advance n rising edges, then land a quarter period after the edge (clock high)
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_wait(input string req, input int n);
    step(n + 2);
    check({req, " ready still low"}, clk_ready, 1'b0);
    step(1);
    check({req, " ready rises"}, clk_ready, 1'b1);
    step(1);
    check("R7 clk_out high phase after ready", clk_out, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pd_n = 1'b1; range_sel = 2'b00; mod_en = 1'b0;
    step(3);
    check("R1 ready in reset", clk_ready, 1'b0);
    check("R1 clk_out in reset", clk_out, 1'b0);
    rst_n = 1'b1;
    step(wait_cycles(2'b00));
    check("R1 R3 ready low before wait end", clk_ready, 1'b0);
    step(1);
    check("R1 R3 ready after reset wait", clk_ready, 1'b1);
    step(1);
    check("R7 clk_out passes", clk_out, 1'b1);

    for (int i = 0; i < 6; i++) begin
      range_sel = VEC[i][2:1];
      mod_en    = VEC[i][0];
      expect_wait((VEC[i][2:1] == 2'b01) ? "R6 long wait" : "R6 short wait",
                  wait_cycles(VEC[i][2:1]));
    end

    // R4: ready drop timing on a change
    mod_en = 1'b1;
    step(2);
    check("R4 ready before drop", clk_ready, 1'b1);
    step(1);
    check("R4 ready dropped", clk_ready, 1'b0);
    step(wait_cycles(2'b00) - 1);
    check("R4 ready low before full wait", clk_ready, 1'b0);
    step(1);
    check("R4 ready after full wait", clk_ready, 1'b1);

    // R8: rewrite same values
    range_sel = 2'b00; mod_en = 1'b1;
    step(10);
    check("R8 ready unchanged", clk_ready, 1'b1);
    check("R8 clk_out still toggles", clk_out, 1'b1);

    // R5: change mid-wait restarts
    range_sel = 2'b01;
    step(12);
    check("R5 mid wait low", clk_ready, 1'b0);
    range_sel = 2'b11;
    step(1);
    expect_wait("R5 restart", wait_cycles(2'b11) - 1 + 1 - 1);

    // R2: power-down
    pd_n = 1'b0;
    step(2);
    check("R2 ready before drop", clk_ready, 1'b1);
    step(1);
    check("R2 ready dropped", clk_ready, 1'b0);
    for (int k = 0; k < 6; k++) begin
      step(1);
      check("R2 clk_out held low", clk_out, 1'b0);
    end
    // power-down interrupts a wait after release, then full wait
    pd_n = 1'b1;
    step(8);
    pd_n = 1'b0;
    step(4);
    check("R2 ready low in power-down", clk_ready, 1'b0);
    check("R2 clk_out low in power-down", clk_out, 1'b0);
    pd_n = 1'b1;
    expect_wait("R3 wake-up", wait_cycles(2'b11));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule